// File: doc/BRIEF.md
# Safe-Bit Receiver with Startup Interlock

This block keeps the local copy of safety bits that remote nodes share over an untrusted link. Bits travel in groups of 16, and a configuration table assigns each group to the one node allowed to send it. An upstream stage has already authenticated and integrity-checked every packet. Such a packet names the sending node, the group and the 16 new bit values. A packet from the wrong node, or one naming a group that is not in use, is dropped.

Each node has its own countdown. It reloads on every packet accepted from that node and steps down once per millisecond tick. If the countdown runs out, that node's bits go to 0. No packet ever signals a fault: a failure shows up only as silence.

Each bit can also be placed under a startup interlock. A bit under the interlock will not show a 1 until a 0 for that bit has been received. That 0 must arrive after reset, or after the most recent timeout of the owning node. The result is a flat image of accepted values that the local logic reads.

Top module: `safe_bit_rx`

## Requirements
- R1: After reset every bit of `image_o` is 0 and every node counts as silent.
- R2: A packet is accepted only if `grp_used_i[g]` is 1 and the owner field `grp_owner_i[g*4 +: 4]` equals the sending node, where g is the group. A rejected packet changes no image bit and does not reload any countdown.
- R3: On an accepted packet, bit i of `pkt_bits_i` is written into image bit g*16+i when `lock_en_i` for that bit is 0. The new value is visible in the cycle after the packet.
- R4: For a bit whose `lock_en_i` is 1, a received 0 is always accepted and arms the bit. A received 1 leaves the bit at 0 unless the bit has been armed since reset or since the last timeout of its owner.
- R5: An armed interlocked bit follows received 0s and 1s directly.
- R6: An accepted packet loads the sender's countdown with T, the node's setting `tmo_cfg_i[n*16 +: 16]`. At the T-th tick with no accepted packet in between, every bit of that node's groups goes to 0 and is disarmed. After T-1 such ticks the bits still hold.
- R7: When a tick and an accepted packet from the same node fall in one cycle, the reload wins and the count restarts at T.
- R8: A timeout setting below 4 is treated as 4.
- R9: A timeout changes only the groups owned by the node that timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_vld_i | input | 1 | A checked packet is present this cycle |
| pkt_node_i | input | 4 | Sending node |
| pkt_grp_i | input | 4 | Group carried by the packet |
| pkt_bits_i | input | 16 | Bit values for that group |
| tmo_cfg_i | input | 256 | Timeout in ms for each node, 16 bits per node |
| grp_owner_i | input | 64 | Owning node for each group, 4 bits per group |
| grp_used_i | input | 16 | Group is allocated |
| lock_en_i | input | 256 | Startup interlock enable for each bit |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| image_o | output | 256 | Accepted bit values |

## Verification
The assertions assume that the allocation, lock mask and timeout settings stay fixed while reset is released. They also assume that packets and ticks last one cycle each, so that an image bit can rise only in the cycle after an accepted packet. The stimulus sets one static configuration before reset is released. It drives each packet or tick as a single-cycle pulse, and it sends every combination of node and group, the owned ones and the foreign ones. A bench model derived from the requirements predicts the image after every step.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    localparam int NODES_DEF   = 16;
    localparam int GROUPS_DEF  = 16;
    localparam int GBITS_DEF   = 16;
    localparam int TMO_W_DEF   = 16;
    localparam int MIN_TMO_DEF = 4;
endpackage

// File: rtl/sbr_node_timer.sv
module sbr_node_timer #(
    parameter int TMO_W   = 16,
    parameter int MIN_TMO = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reload_i,
    input  logic [TMO_W-1:0] cfg_i,
    input  logic             tick_i,
    output logic             alive_o,
    output logic             expire_o
);
    typedef struct packed {
        logic             alive;
        logic [TMO_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic expire_d;
    logic [TMO_W-1:0] load_val;

    always_comb begin
        tmr_d    = tmr_q;
        expire_d = 1'b0;
        // R8: settings under the floor are raised to it
        load_val = (cfg_i < TMO_W'(MIN_TMO)) ? TMO_W'(MIN_TMO) : cfg_i;
        if (reload_i) begin
            // R7: reload has priority over a coincident tick
            tmr_d.cnt   = load_val;
            tmr_d.alive = 1'b1;
        end else if (tick_i && tmr_q.alive) begin
            if (tmr_q.cnt <= TMO_W'(1)) begin
                tmr_d.alive = 1'b0;
                tmr_d.cnt   = '0;
                expire_d    = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - TMO_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign alive_o  = tmr_q.alive;
    assign expire_o = expire_d;
endmodule

// File: rtl/sbr_admit.sv
module sbr_admit #(
    parameter int NODES  = 16,
    parameter int GROUPS = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int GRP_W  = $clog2(GROUPS)
) (
    input  logic                     pkt_vld_i,
    input  logic [NODE_W-1:0]        pkt_node_i,
    input  logic [GRP_W-1:0]         pkt_grp_i,
    input  logic [GROUPS-1:0]        grp_used_i,
    input  logic [GROUPS*NODE_W-1:0] grp_owner_i,
    input  logic [NODES-1:0]         expire_i,
    output logic [NODES-1:0]         node_reload_o,
    output logic [GROUPS-1:0]        grp_load_o,
    output logic [GROUPS-1:0]        grp_clear_o
);
    logic [NODE_W-1:0] pkt_owner;
    logic              accept;

    always_comb begin
        pkt_owner = grp_owner_i[pkt_grp_i*NODE_W +: NODE_W];
        // R2: group must be allocated and owned by the sender
        accept = pkt_vld_i && grp_used_i[pkt_grp_i] && (pkt_owner == pkt_node_i);

        node_reload_o = '0;
        grp_load_o    = '0;
        if (accept) begin
            node_reload_o[pkt_node_i] = 1'b1;
            grp_load_o[pkt_grp_i]     = 1'b1;
        end

        // R9: only groups of an expiring node are cleared
        for (int g = 0; g < GROUPS; g++) begin
            grp_clear_o[g] = expire_i[grp_owner_i[g*NODE_W +: NODE_W]];
        end
    end
endmodule

// File: rtl/sbr_group_image.sv
module sbr_group_image #(
    parameter int GBITS = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic [GBITS-1:0] bits_i,
    input  logic [GBITS-1:0] lock_i,
    output logic [GBITS-1:0] img_o
);
    typedef struct packed {
        logic [GBITS-1:0] val;
        logic [GBITS-1:0] armed;
    } grp_t;

    grp_t grp_d, grp_q;

    always_comb begin
        grp_d = grp_q;
        if (clear_i) begin
            // R6: silence drops values and disarms
            grp_d = '0;
        end else if (load_i) begin
            for (int i = 0; i < GBITS; i++) begin
                if (!bits_i[i]) begin
                    grp_d.val[i]   = 1'b0;
                    grp_d.armed[i] = 1'b1;
                end else begin
                    // R3 direct, R4/R5 interlocked
                    grp_d.val[i] = !lock_i[i] || grp_q.armed[i];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) grp_q <= '0;
        else         grp_q <= grp_d;
    end

    assign img_o = grp_q.val;
endmodule

// File: rtl/safe_bit_rx.sv
module safe_bit_rx #(
    parameter int NODES   = sbr_pkg::NODES_DEF,
    parameter int GROUPS  = sbr_pkg::GROUPS_DEF,
    parameter int GBITS   = sbr_pkg::GBITS_DEF,
    parameter int TMO_W   = sbr_pkg::TMO_W_DEF,
    parameter int MIN_TMO = sbr_pkg::MIN_TMO_DEF,
    localparam int NODE_W = $clog2(NODES),
    localparam int GRP_W  = $clog2(GROUPS),
    localparam int TOTAL  = GROUPS * GBITS
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     pkt_vld_i,
    input  logic [NODE_W-1:0]        pkt_node_i,
    input  logic [GRP_W-1:0]         pkt_grp_i,
    input  logic [GBITS-1:0]         pkt_bits_i,
    input  logic [NODES*TMO_W-1:0]   tmo_cfg_i,
    input  logic [GROUPS*NODE_W-1:0] grp_owner_i,
    input  logic [GROUPS-1:0]        grp_used_i,
    input  logic [TOTAL-1:0]         lock_en_i,
    input  logic                     tick_ms_i,
    output logic [TOTAL-1:0]         image_o
);
    logic [NODES-1:0]  node_reload;
    logic [NODES-1:0]  node_alive;
    logic [NODES-1:0]  node_expire;
    logic [GROUPS-1:0] grp_load;
    logic [GROUPS-1:0] grp_clear;

    sbr_admit #(.NODES(NODES), .GROUPS(GROUPS)) u_admit (
        .pkt_vld_i     (pkt_vld_i),
        .pkt_node_i    (pkt_node_i),
        .pkt_grp_i     (pkt_grp_i),
        .grp_used_i    (grp_used_i),
        .grp_owner_i   (grp_owner_i),
        .expire_i      (node_expire),
        .node_reload_o (node_reload),
        .grp_load_o    (grp_load),
        .grp_clear_o   (grp_clear)
    );

    for (genvar n = 0; n < NODES; n++) begin : g_node
        sbr_node_timer #(.TMO_W(TMO_W), .MIN_TMO(MIN_TMO)) u_tmr (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .reload_i (node_reload[n]),
            .cfg_i    (tmo_cfg_i[n*TMO_W +: TMO_W]),
            .tick_i   (tick_ms_i),
            .alive_o  (node_alive[n]),
            .expire_o (node_expire[n])
        );
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        sbr_group_image #(.GBITS(GBITS)) u_img (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .load_i  (grp_load[g]),
            .clear_i (grp_clear[g]),
            .bits_i  (pkt_bits_i),
            .lock_i  (lock_en_i[g*GBITS +: GBITS]),
            .img_o   (image_o[g*GBITS +: GBITS])
        );
    end

    logic unused_alive;
    assign unused_alive = ^node_alive;
endmodule

// File: rtl/safe_bit_rx_sva.sv
module safe_bit_rx_sva #(
    parameter int NODES  = 16,
    parameter int GROUPS = 16,
    parameter int GBITS  = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int GRP_W  = $clog2(GROUPS),
    localparam int TOTAL  = GROUPS * GBITS
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     pkt_vld_i,
    input logic [NODE_W-1:0]        pkt_node_i,
    input logic [GRP_W-1:0]         pkt_grp_i,
    input logic [GBITS-1:0]         pkt_bits_i,
    input logic [GROUPS*NODE_W-1:0] grp_owner_i,
    input logic [GROUPS-1:0]        grp_used_i,
    input logic [TOTAL-1:0]         lock_en_i,
    input logic                     tick_ms_i,
    input logic [TOTAL-1:0]         image_o
);
    logic owned;
    assign owned = grp_used_i[pkt_grp_i] &&
                   (grp_owner_i[pkt_grp_i*NODE_W +: NODE_W] == pkt_node_i);

    a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (image_o == '0));

    a_r2_rejected_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_vld_i && !owned && !tick_ms_i) |=> $stable(image_o));

    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pkt_vld_i && !tick_ms_i) |=> $stable(image_o));

    a_r3_direct_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_vld_i && owned) |=>
        ((image_o[$past(pkt_grp_i)*GBITS +: GBITS] & ~$past(lock_en_i[pkt_grp_i*GBITS +: GBITS]))
         == ($past(pkt_bits_i) & ~$past(lock_en_i[pkt_grp_i*GBITS +: GBITS]))));

    a_r6_tick_only_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pkt_vld_i |=> ((image_o & ~$past(image_o)) == '0));
endmodule

bind safe_bit_rx safe_bit_rx_sva #(.NODES(NODES), .GROUPS(GROUPS), .GBITS(GBITS)) u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pkt_vld_i   (pkt_vld_i),
    .pkt_node_i  (pkt_node_i),
    .pkt_grp_i   (pkt_grp_i),
    .pkt_bits_i  (pkt_bits_i),
    .grp_owner_i (grp_owner_i),
    .grp_used_i  (grp_used_i),
    .lock_en_i   (lock_en_i),
    .tick_ms_i   (tick_ms_i),
    .image_o     (image_o)
);

// File: tb/safe_bit_rx_tb.sv
module safe_bit_rx_tb;
    localparam int NODES = 16, GROUPS = 16, GBITS = 16, TMO_W = 16;
    localparam int TOTAL = GROUPS * GBITS;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  pkt_vld = 1'b0;
    logic [3:0]            pkt_node = '0;
    logic [3:0]            pkt_grp = '0;
    logic [15:0]           pkt_bits = '0;
    logic [NODES*TMO_W-1:0] tmo_cfg;
    logic [GROUPS*4-1:0]   grp_owner;
    logic [GROUPS-1:0]     grp_used;
    logic [TOTAL-1:0]      lock_en;
    logic                  tick = 1'b0;
    logic [TOTAL-1:0]      image;

    int checks = 0, errors = 0;
    bit done = 0;

    int m_cnt[NODES];
    bit m_alive[NODES];
    bit m_val[TOTAL];
    bit m_arm[TOTAL];

    always #5 clk = ~clk;

    safe_bit_rx u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pkt_vld_i(pkt_vld), .pkt_node_i(pkt_node),
        .pkt_grp_i(pkt_grp), .pkt_bits_i(pkt_bits), .tmo_cfg_i(tmo_cfg),
        .grp_owner_i(grp_owner), .grp_used_i(grp_used), .lock_en_i(lock_en),
        .tick_ms_i(tick), .image_o(image)
    );

    function automatic int owner_of(int g);
        if (g < 12) return g / 2;
        if (g == 12) return 7;
        if (g == 14) return 6;
        return 0;
    endfunction

    function automatic bit used_of(int g);
        return (g != 13) && (g != 15);
    endfunction

    function automatic int tmo_of(int n);
        int t = n + 2;
        return (t < 4) ? 4 : t;  // R8 floor
    endfunction

    task automatic model(bit vld, int node, int grp, logic [15:0] bits, bit tk);
        bit acc = vld && used_of(grp) && (owner_of(grp) == node);
        for (int n = 0; n < NODES; n++) begin
            if (acc && node == n) begin
                m_cnt[n] = tmo_of(n); m_alive[n] = 1;
            end else if (tk && m_alive[n]) begin
                if (m_cnt[n] <= 1) begin
                    m_alive[n] = 0; m_cnt[n] = 0;
                    for (int g = 0; g < GROUPS; g++)
                        if (owner_of(g) == n)
                            for (int i = 0; i < GBITS; i++) begin
                                m_val[g*GBITS+i] = 0; m_arm[g*GBITS+i] = 0;
                            end
                end else m_cnt[n] = m_cnt[n] - 1;
            end
        end
        if (acc)
            for (int i = 0; i < GBITS; i++) begin
                int b = grp*GBITS + i;
                if (!bits[i]) begin m_val[b] = 0; m_arm[b] = 1; end
                else m_val[b] = !lock_en[b] || m_arm[b];
            end
    endtask

    task automatic compare(string tag);
        logic [TOTAL-1:0] exp;
        for (int b = 0; b < TOTAL; b++) exp[b] = m_val[b];
        checks++;
        if (image !== exp) begin
            errors++;
            $display("FAIL %s image=%h expected=%h", tag, image, exp);
        end
    endtask

    task automatic step(bit vld, int node, int grp, logic [15:0] bits, bit tk, string tag);
        @(negedge clk);
        pkt_vld = vld; pkt_node = 4'(node); pkt_grp = 4'(grp); pkt_bits = bits; tick = tk;
        @(posedge clk);
        model(vld, node, grp, bits, tk);
        @(negedge clk);
        pkt_vld = 0; tick = 0;
        compare(tag);
    endtask

    initial begin
        for (int n = 0; n < NODES; n++) tmo_cfg[n*TMO_W +: TMO_W] = TMO_W'(n + 2);
        for (int g = 0; g < GROUPS; g++) begin
            grp_owner[g*4 +: 4] = 4'(owner_of(g));
            grp_used[g] = used_of(g);
        end
        for (int b = 0; b < TOTAL; b++) lock_en[b] = (b % 3 == 0);
        for (int n = 0; n < NODES; n++) begin m_cnt[n] = 0; m_alive[n] = 0; end
        for (int b = 0; b < TOTAL; b++) begin m_val[b] = 0; m_arm[b] = 0; end

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        compare("R1 reset image");

        // R4: ones before any zero, interlocked bits must stay 0
        for (int g = 0; g < GROUPS; g++)
            if (used_of(g)) step(1, owner_of(g), g, 16'hFFFF, 0, "R4 unarmed ones");
        // R4: zeros are accepted and arm
        for (int g = 0; g < GROUPS; g++)
            if (used_of(g)) step(1, owner_of(g), g, 16'h0000, 0, "R4 zero arms");
        // R3/R5: mixed patterns after arming
        for (int g = 0; g < GROUPS; g++)
            if (used_of(g)) begin
                step(1, owner_of(g), g, 16'hA5C3 ^ 16'(g * 16'h1111), 0, "R5 armed pattern");
                step(1, owner_of(g), g, 16'h5A3C, 0, "R3 direct pattern");
            end
        // R2: every foreign or unused combination is dropped
        for (int n = 0; n < NODES; n++)
            for (int g = 0; g < GROUPS; g++)
                if (!(used_of(g) && owner_of(g) == n))
                    step(1, n, g, 16'hFFFF ^ 16'(n), 0, "R2 rejected packet");

        // R7: packet and tick in the same cycle, reload wins
        step(1, owner_of(0), 0, 16'hFFFF, 1, "R7 reload with tick");
        // R6/R8/R9: tick sweep, every node expires at its own count
        for (int t = 0; t < 12; t++) step(0, 0, 0, 16'h0, 1, "R6 R8 R9 tick sweep");

        // R4: after a timeout the interlock must be re-armed
        step(1, owner_of(0), 0, 16'hFFFF, 0, "R4 after timeout");
        step(1, owner_of(0), 0, 16'h0000, 0, "R4 rearm");
        step(1, owner_of(0), 0, 16'hFFFF, 0, "R5 after rearm");
        for (int t = 0; t < 5; t++) step(0, 0, 0, 16'h0, 1, "R8 floor timeout");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule